// File: doc/BRIEF.md
# Branch Resolve and Next-PC Unit

This block works out where instruction fetch goes next for a 32-bit fixed-length instruction set that has one architectural delay slot. Each cycle, decode presents one instruction with its PC, a branch-kind code, the two source register values, the 16-bit relative offset and the 26-bit jump index. The block compares the register values directly, because the instruction set has no condition codes. It then reports whether the transfer is taken and, for the linking forms, asks for the return address to be written to register 31.

Redirection is delayed by one instruction. While a branch is being resolved, the next PC is always the sequential address, so the delay-slot instruction is fetched and executed. A taken branch leaves its target in a pending register. The next valid instruction, which is the delay slot, then steers fetch to that target. Bubble cycles with no valid instruction keep the pending state unchanged. A branch placed in a delay slot gives undefined results.

Top module: `npc_unit`

## Requirements
- R1: Kind code 1 is taken when `rsVal` equals `rtVal`. Kind code 2 is taken when they differ.
- R2: Kind codes 3, 4, 5 and 6 compare `rsVal`, read as a signed two's-complement value, against zero. They are taken for <= 0, > 0, < 0 and >= 0 respectively.
- R3: Kind codes 7 (taken when rs < 0) and 8 (taken when rs >= 0) request a link write whether or not they are taken. Kind code 10 is always taken and always links.
- R4: For kind codes 1 to 8, the target is PC+4 plus the offset sign-extended to 32 bits and shifted left by 2.
- R5: Kind codes 9 and 10 are always taken. Their target is bits 31:28 of PC+4 followed by the 26-bit index followed by two zero bits.
- R6: Kind code 11 is always taken, and its target is `rsVal`.
- R7: In the cycle a valid branch or jump is presented, `nextPc` is PC+4, so the delay-slot instruction runs.
- R8: For the next valid instruction after a taken transfer, `nextPc` is the stored target and `slotRedirect` is 1. After that instruction, fetch is sequential again.
- R9: A link request drives `linkWe` high, `linkIdx` to 31 and `linkAddr` to PC+8.
- R10: When `instValid` is 0, `taken` and `linkWe` are 0, and any pending target is kept for the next valid instruction.
- R11: After reset, nothing is pending: `slotRedirect` is 0 and `nextPc` is PC+4.
- R12: Kind codes 0 and 12 to 15 are never taken, never link, and leave nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | A decoded instruction is present this cycle |
| pc | input | 32 | Address of the presented instruction |
| brKind | input | 4 | Branch kind code (see requirements) |
| rsVal | input | 32 | First source register value |
| rtVal | input | 32 | Second source register value |
| brOffset | input | 16 | Relative offset in instruction words |
| jmpIndex | input | 26 | Region jump index |
| nextPc | output | 32 | Address to fetch next |
| taken | output | 1 | Presented transfer is taken |
| slotRedirect | output | 1 | A stored target is steering `nextPc` |
| linkWe | output | 1 | Write the return address |
| linkIdx | output | 5 | Link destination register (31) |
| linkAddr | output | 32 | Return address PC+8 |

## Verification
`taken`, `linkWe`, `linkIdx`, `linkAddr` and the branch cycle's `nextPc` are combinational, so the bench drives inputs at the falling edge and checks one time step later, in the same cycle. The redirect passes through one register. It is therefore checked on the next valid instruction, after at least one rising edge, and sometimes after an intervening bubble cycle. The sweep covers every kind code against a grid of operands and offsets, with signed boundary values included. It adds a jump whose PC+4 crosses a 256 MB region and a reset taken while a target is pending.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    KIND_NONE   = 4'd0,
    KIND_EQ     = 4'd1,
    KIND_NE     = 4'd2,
    KIND_LEZ    = 4'd3,
    KIND_GTZ    = 4'd4,
    KIND_LTZ    = 4'd5,
    KIND_GEZ    = 4'd6,
    KIND_LTZ_LK = 4'd7,
    KIND_GEZ_LK = 4'd8,
    KIND_JREG   = 4'd9,
    KIND_JREG_LK= 4'd10,
    KIND_JR     = 4'd11
  } brKind_e;

  typedef enum logic [1:0] {
    SEL_REL    = 2'd0,
    SEL_REGION = 2'd1,
    SEL_RS     = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic eq;
    logic neg;
    logic zero;
  } cmpFlags_t;

  typedef struct packed {
    logic    commit;
    logic    take;
    logic    link;
    tgtSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic        instValid,
  input  logic [3:0]  brKind,
  input  cmpFlags_t   flags,
  output ctrlStrobe_t strobe
);

  logic condTake;
  logic isLink;
  tgtSel_e sel;

  always_comb begin
    condTake = 1'b0;
    isLink   = 1'b0;
    sel      = SEL_REL;
    case (brKind)
      KIND_EQ:      condTake = flags.eq;
      KIND_NE:      condTake = ~flags.eq;
      KIND_LEZ:     condTake = flags.neg | flags.zero;
      KIND_GTZ:     condTake = ~flags.neg & ~flags.zero;
      KIND_LTZ:     condTake = flags.neg;
      KIND_GEZ:     condTake = ~flags.neg;
      KIND_LTZ_LK: begin
        condTake = flags.neg;
        isLink   = 1'b1;
      end
      KIND_GEZ_LK: begin
        condTake = ~flags.neg;
        isLink   = 1'b1;
      end
      KIND_JREG: begin
        condTake = 1'b1;
        sel      = SEL_REGION;
      end
      KIND_JREG_LK: begin
        condTake = 1'b1;
        isLink   = 1'b1;
        sel      = SEL_REGION;
      end
      KIND_JR: begin
        condTake = 1'b1;
        sel      = SEL_RS;
      end
      default: begin
        condTake = 1'b0;
        isLink   = 1'b0;
      end
    endcase
  end

  always_comb begin
    strobe.commit = instValid;
    strobe.take   = instValid & condTake;
    strobe.link   = instValid & isLink;
    strobe.sel    = sel;
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic [OFF_W-1:0] brOffset,
  input  logic [IDX_W-1:0] jmpIndex,
  input  ctrlStrobe_t      strobe,
  output cmpFlags_t        flags,
  output logic [XLEN-1:0]  nextPc,
  output logic             slotRedirect,
  output logic [XLEN-1:0]  linkAddr
);

  localparam int INST_BYTES = 4;
  localparam int SHIFT      = 2;
  localparam int EXT_W      = XLEN - OFF_W - SHIFT;
  localparam int LOW_W      = IDX_W + SHIFT;
  localparam logic [XLEN-1:0] REGION_MASK = ~((XLEN'(1) << LOW_W) - XLEN'(1));

  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] pcPlus8;
  logic [XLEN-1:0] relDisp;
  logic [XLEN-1:0] relTarget;
  logic [XLEN-1:0] regionTarget;
  logic [XLEN-1:0] chosenTarget;
  logic [XLEN-1:0] pendTarget;
  logic            pendValid;

  assign pcPlus4 = pc + XLEN'(INST_BYTES);
  assign pcPlus8 = pc + XLEN'(2 * INST_BYTES);

  assign relDisp      = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, {SHIFT{1'b0}}};
  assign relTarget    = pcPlus4 + relDisp;
  assign regionTarget = (pcPlus4 & REGION_MASK) | XLEN'({jmpIndex, {SHIFT{1'b0}}});

  always_comb begin
    flags.eq   = (rsVal == rtVal);
    flags.neg  = rsVal[XLEN-1];
    flags.zero = (rsVal == '0);
  end

  always_comb begin
    case (strobe.sel)
      SEL_REGION: chosenTarget = regionTarget;
      SEL_RS:     chosenTarget = rsVal;
      default:    chosenTarget = relTarget;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendTarget <= '0;
    end else if (strobe.commit) begin
      pendValid  <= strobe.take;
      pendTarget <= chosenTarget;
    end
  end

  assign slotRedirect = pendValid;
  assign nextPc       = pendValid ? pendTarget : pcPlus4;
  assign linkAddr     = pcPlus8;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        brKind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [IDX_W-1:0]  jmpIndex,
  output logic [XLEN-1:0]   nextPc,
  output logic              taken,
  output logic              slotRedirect,
  output logic              linkWe,
  output logic [RIDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]   linkAddr
);

  ctrlStrobe_t strobe;
  cmpFlags_t   flags;

  npc_ctrl i_ctrl (
    .instValid (instValid),
    .brKind    (brKind),
    .flags     (flags),
    .strobe    (strobe)
  );

  npc_datapath #(
    .XLEN  (XLEN),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pc           (pc),
    .rsVal        (rsVal),
    .rtVal        (rtVal),
    .brOffset     (brOffset),
    .jmpIndex     (jmpIndex),
    .strobe       (strobe),
    .flags        (flags),
    .nextPc       (nextPc),
    .slotRedirect (slotRedirect),
    .linkAddr     (linkAddr)
  );

  assign taken   = strobe.take;
  assign linkWe  = strobe.link;
  assign linkIdx = RIDX_W'(LINK_REG);

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [3:0]        brKind,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   rsVal,
  input logic [XLEN-1:0]   nextPc,
  input logic              taken,
  input logic              slotRedirect,
  input logic              linkWe,
  input logic [RIDX_W-1:0] linkIdx,
  input logic [XLEN-1:0]   linkAddr
);

  p_branch_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && taken && !slotRedirect) |-> nextPc == pc + XLEN'(4));

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && taken) |=> slotRedirect);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !taken) |=> !slotRedirect);

  p_link_r9: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkIdx == RIDX_W'(31) && linkAddr == pc + XLEN'(8)));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!taken && !linkWe));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> slotRedirect == $past(slotRedirect));

  p_jump_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && brKind == 4'd11) |=> nextPc == $past(rsVal));

  p_dead_r12: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd0 || brKind >= 4'd12) |-> (!taken && !linkWe));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) i_npc_chk (
  .clk          (clk),
  .rstN         (rstN),
  .instValid    (instValid),
  .brKind       (brKind),
  .pc           (pc),
  .rsVal        (rsVal),
  .nextPc       (nextPc),
  .taken        (taken),
  .slotRedirect (slotRedirect),
  .linkWe       (linkWe),
  .linkIdx      (linkIdx),
  .linkAddr     (linkAddr)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  brKind = '0;
  logic [31:0] pc = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [15:0] brOffset = '0;
  logic [25:0] jmpIndex = '0;
  logic [31:0] nextPc;
  logic        taken;
  logic        slotRedirect;
  logic        linkWe;
  logic [4:0]  linkIdx;
  logic [31:0] linkAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .brKind(brKind),
    .pc(pc), .rsVal(rsVal), .rtVal(rtVal), .brOffset(brOffset),
    .jmpIndex(jmpIndex), .nextPc(nextPc), .taken(taken),
    .slotRedirect(slotRedirect), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkAddr(linkAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h kind=%0d pc=%h rs=%h rt=%h",
               req, act, exp, brKind, pc, rsVal, rtVal);
    end
  endtask

  function automatic bit expTake(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) <= 0;
      4'd4: return $signed(a) > 0;
      4'd5, 4'd7: return $signed(a) < 0;
      4'd6, 4'd8: return $signed(a) >= 0;
      4'd9, 4'd10, 4'd11: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expLink(input logic [3:0] k);
    return (k == 4'd7) || (k == 4'd8) || (k == 4'd10);
  endfunction

  function automatic logic [31:0] expTarget(input logic [3:0] k, input logic [31:0] p,
                                            input logic [31:0] a, input logic [15:0] off,
                                            input logic [25:0] idx);
    logic [31:0] p4;
    p4 = p + 32'd4;
    if (k == 4'd11) return a;
    if (k == 4'd9 || k == 4'd10) return {p4[31:28], idx, 2'b00};
    return p4 + (32'($signed(off)) * 32'd4);
  endfunction

  function automatic string tagOf(input logic [3:0] k);
    case (k)
      4'd1, 4'd2: return "R1";
      4'd3, 4'd4, 4'd5, 4'd6: return "R2";
      4'd7, 4'd8, 4'd10: return "R3";
      4'd9: return "R5";
      4'd11: return "R6";
      default: return "R12";
    endcase
  endfunction

  // One branch followed by its delay slot (optionally after a bubble)
  task automatic runPair(input logic [3:0] k, input logic [31:0] p, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] off, input logic [25:0] idx,
                         input bit bubble);
    bit t;
    bit l;
    logic [31:0] tgt;
    t   = expTake(k, a, b);
    l   = expLink(k);
    tgt = expTarget(k, p, a, off, idx);
    @(negedge clk);
    instValid = 1'b1; brKind = k; pc = p; rsVal = a; rtVal = b;
    brOffset = off; jmpIndex = idx;
    #1;
    chk(tagOf(k), {31'd0, taken}, {31'd0, t});
    chk("R7", nextPc, p + 32'd4);
    chk("R3", {31'd0, linkWe}, {31'd0, l});
    if (l) begin
      chk("R9", {27'd0, linkIdx}, 32'd31);
      chk("R9", linkAddr, p + 32'd8);
    end
    if (bubble) begin
      @(negedge clk);
      instValid = 1'b0; brKind = 4'd10; pc = 32'h1234_5678;
      #1;
      chk("R10", {30'd0, taken, linkWe}, 32'd0);
    end
    @(negedge clk);
    instValid = 1'b1; brKind = 4'd0; pc = p + 32'd4; rsVal = 32'd0; rtVal = 32'd1;
    #1;
    if (t) begin
      chk((k <= 4'd8) ? "R4" : tagOf(k), nextPc, tgt);
      chk("R8", {31'd0, slotRedirect}, 32'd1);
    end else begin
      chk("R12", nextPc, p + 32'd8);
      chk("R8", {31'd0, slotRedirect}, 32'd0);
    end
    @(negedge clk);
    brKind = 4'd0; pc = p + 32'd8;
    #1;
    chk("R8", nextPc, p + 32'd12);
  endtask

  initial begin
    logic [31:0] vals [6];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;

    // R11: reset state
    pc = 32'h0000_1000; instValid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", {31'd0, slotRedirect}, 32'd0);
    chk("R11", nextPc, 32'h0000_1004);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [31:0] p;
          logic [15:0] off;
          p   = 32'h0040_0000 + 32'(k * 4096 + i * 256 + j * 16);
          off = ((i + j) % 2 == 0) ? 16'(i * 300 + j) : 16'(-(j * 77 + i + 1));
          runPair(4'(k), p, vals[i], vals[j], off, 26'(32'h155_5555 ^ 32'(i * 7919 + j)),
                  ((i + j) % 3) == 0);
        end
      end
    end

    // R5: PC+4 crosses into a new 256 MB region
    runPair(4'd9, 32'h8FFF_FFFC, 32'd0, 32'd0, 16'd0, 26'h3FF_FFFF, 1'b0);
    runPair(4'd10, 32'h8FFF_FFFC, 32'd0, 32'd0, 16'd0, 26'h000_0001, 1'b1);
    // R4: extreme offsets
    runPair(4'd1, 32'h0002_0000, 32'd9, 32'd9, 16'h8000, 26'd0, 1'b0);
    runPair(4'd1, 32'h0002_0000, 32'd9, 32'd9, 16'h7FFF, 26'd0, 1'b0);

    // R11: reset while a target is pending
    @(negedge clk);
    instValid = 1'b1; brKind = 4'd11; pc = 32'h0000_2000; rsVal = 32'hABCD_0000;
    @(negedge clk);
    rstN = 1'b0; brKind = 4'd0; pc = 32'h0000_2004;
    #1;
    chk("R11", {31'd0, slotRedirect}, 32'd0);
    chk("R11", nextPc, 32'h0000_2008);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule